// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block holds the status byte and the retry counter of one USB host transfer descriptor. After each bus transaction the scheduler reports what happened. The report is a single outcome code, and it arrives with the endpoint speed and a flag saying whether the queue is on the periodic schedule. The block folds that outcome into the status byte one clock later. It also pulses an indication when the descriptor must halt, when it retires normally, or when the bus must be forced to time out.

Several error flags are sticky: once raised, they stay raised until software reloads the descriptor. A STALL handshake, babble, or running out of retries halts the descriptor, and any update that halts also drops the Active bit. Outcomes that arrive while Active is low change nothing. Software seeds the byte and the counter through a load strobe. The load takes priority over a report that arrives in the same cycle.

Top module: `td_status_updater`

## Requirements
- R1: After reset, `status` is 0x00, `cerr` is 0, and `halt_pulse`, `retire_pulse` and `force_timeout` are 0.
- R2: When `sw_load` is high, `status` and `cerr` take `sw_status` and `sw_cerr` on the next cycle, and no pulse is raised. A `txn_valid` in the same cycle is discarded.
- R3: When status bit 7 (Active) is 0, a reported outcome leaves `status` and `cerr` unchanged and raises no pulse.
- R4: Outcome code 1 (STALL) sets bit 6 (Halted), clears bit 7 and raises `halt_pulse` for one cycle.
- R5: Outcome code 2 (babble) sets bit 4 and bit 6, clears bit 7 and raises `halt_pulse`.
- R6: Outcome codes 3 (timeout), 4 (CRC) and 5 (bad PID) set bit 3. If `cerr` is nonzero it decrements by one; if that decrement reaches 0, the same update also sets bit 6, clears bit 7 and raises `halt_pulse`. A `cerr` of 0 means unlimited retries: it stays 0 and no halt occurs.
- R7: Outcome codes 6 (receive overrun) and 7 (transmit underrun) set bit 5. Only code 6 also raises `force_timeout` for one cycle.
- R8: Outcome code 8 (missed complete-split) sets bit 2 only when `ep_speed` is 00 (full) or 01 (low) and `periodic` is 1. Otherwise it changes nothing.
- R9: Bits 5, 3 and 2 stay set through every later outcome, including success. Bits 1 and 0 are never changed by an outcome.
- R10: Outcome code 0 (success) with `txn_last` high clears bit 7 and raises `retire_pulse`. Without `txn_last` it changes nothing. Codes 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_load | input | 1 | Software load strobe |
| sw_status | input | 8 | Status byte to load |
| sw_cerr | input | CERR_W | Retry count to load |
| txn_valid | input | 1 | A transaction outcome is reported this cycle |
| txn_result | input | 4 | Outcome code |
| txn_last | input | 1 | Transaction completed the transfer |
| ep_speed | input | 2 | Endpoint speed: 00 full, 01 low, 10 high |
| periodic | input | 1 | Queue is on the periodic schedule |
| status | output | 8 | Current status byte |
| cerr | output | CERR_W | Current retry count |
| halt_pulse | output | 1 | Descriptor halted by the last update |
| retire_pulse | output | 1 | Descriptor retired normally by the last update |
| force_timeout | output | 1 | Force a bus timeout after an overrun |

## Verification
The case where two functions meet in one cycle is a transaction error that also drains the last retry. A single update must then set Transaction Error and Halted together, clear Active and pulse the halt. The bench provokes this by loading a count of one and reporting a timeout, and separately by letting a count of three run down across mixed outcomes. Each expected byte is worked out by hand from the rules. A second collision, a load and an outcome in the same cycle, is judged by checking that the loaded value appears unaltered.

// File: rtl/td_status_pkg.sv
package td_status_pkg;
   localparam int ST_W   = 8;
   localparam int RES_W  = 4;
   localparam int SPD_W  = 2;

   localparam int B_ACT  = 7;
   localparam int B_HLT  = 6;
   localparam int B_DBE  = 5;
   localparam int B_BAB  = 4;
   localparam int B_XER  = 3;
   localparam int B_MMF  = 2;

   localparam logic [SPD_W-1:0] SPD_FULL = 2'b00;
   localparam logic [SPD_W-1:0] SPD_LOW  = 2'b01;
   localparam logic [SPD_W-1:0] SPD_HIGH = 2'b10;

   localparam logic [RES_W-1:0] RES_OK       = 4'd0;
   localparam logic [RES_W-1:0] RES_STALL    = 4'd1;
   localparam logic [RES_W-1:0] RES_BABBLE   = 4'd2;
   localparam logic [RES_W-1:0] RES_TIMEOUT  = 4'd3;
   localparam logic [RES_W-1:0] RES_CRC      = 4'd4;
   localparam logic [RES_W-1:0] RES_BADPID   = 4'd5;
   localparam logic [RES_W-1:0] RES_OVERRUN  = 4'd6;
   localparam logic [RES_W-1:0] RES_UNDERRUN = 4'd7;
   localparam logic [RES_W-1:0] RES_MISSED   = 4'd8;

   typedef struct packed {
      logic ok;
      logic stall;
      logic babble;
      logic xact;
      logic overrun;
      logic underrun;
      logic missed;
   } evt_t;
endpackage

// File: rtl/td_result_decode.sv
module td_result_decode
   import td_status_pkg::*;
#(
   parameter bit SPLIT_QUALIFY = 1'b1
) (
   input  logic             valid,
   input  logic [RES_W-1:0] code,
   input  logic [SPD_W-1:0] speed,
   input  logic             periodic,
   output evt_t             evt
);
   logic split_ok;

   generate
      if (SPLIT_QUALIFY) begin : g_split_qual
         assign split_ok = periodic && ((speed == SPD_FULL) || (speed == SPD_LOW));
      end else begin : g_split_any
         logic unused_ctx;
         assign unused_ctx = ^{speed, periodic};
         assign split_ok   = 1'b1;
      end
   endgenerate

   always_comb begin
      evt = '0;
      if (valid) begin
         unique case (code)
            RES_OK:       evt.ok       = 1'b1;
            RES_STALL:    evt.stall    = 1'b1;
            RES_BABBLE:   evt.babble   = 1'b1;
            RES_TIMEOUT,
            RES_CRC,
            RES_BADPID:   evt.xact     = 1'b1;
            RES_OVERRUN:  evt.overrun  = 1'b1;
            RES_UNDERRUN: evt.underrun = 1'b1;
            RES_MISSED:   evt.missed   = split_ok;
            default:      evt          = '0;
         endcase
      end
   end
endmodule

// File: rtl/td_cerr_step.sv
module td_cerr_step #(
   parameter int CERR_W = 2
) (
   input  logic [CERR_W-1:0] cur,
   input  logic              dec,
   output logic [CERR_W-1:0] nxt,
   output logic              exhausted
);
   localparam logic [CERR_W-1:0] ONE  = CERR_W'(1);
   localparam logic [CERR_W-1:0] ZERO = '0;

   always_comb begin
      nxt       = cur;
      exhausted = 1'b0;
      if (dec && (cur != ZERO)) begin
         nxt       = cur - ONE;
         exhausted = (cur == ONE);
      end
   end
endmodule

// File: rtl/td_status_merge.sv
module td_status_merge
   import td_status_pkg::*;
(
   input  logic [ST_W-1:0] cur_st,
   input  evt_t            evt,
   input  logic            last,
   input  logic            exhausted,
   output logic [ST_W-1:0] nxt_st,
   output logic            halt,
   output logic            retire,
   output logic            abort
);
   logic active;
   assign active = cur_st[B_ACT];

   always_comb begin
      nxt_st = cur_st;
      halt   = 1'b0;
      retire = 1'b0;
      abort  = 1'b0;
      if (active) begin
         if (evt.stall)  nxt_st[B_HLT] = 1'b1;
         if (evt.babble) begin
            nxt_st[B_BAB] = 1'b1;
            nxt_st[B_HLT] = 1'b1;
         end
         if (evt.xact) begin
            nxt_st[B_XER] = 1'b1;
            if (exhausted) nxt_st[B_HLT] = 1'b1;
         end
         if (evt.overrun || evt.underrun) nxt_st[B_DBE] = 1'b1;
         if (evt.missed) nxt_st[B_MMF] = 1'b1;
         halt   = evt.stall || evt.babble || (evt.xact && exhausted);
         retire = evt.ok && last;
         abort  = evt.overrun;
         if (halt || retire) nxt_st[B_ACT] = 1'b0;
      end
   end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
   import td_status_pkg::*;
#(
   parameter int CERR_W        = 2,
   parameter bit SPLIT_QUALIFY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_load,
   input  logic [7:0]        sw_status,
   input  logic [CERR_W-1:0] sw_cerr,
   input  logic              txn_valid,
   input  logic [3:0]        txn_result,
   input  logic              txn_last,
   input  logic [1:0]        ep_speed,
   input  logic              periodic,
   output logic [7:0]        status,
   output logic [CERR_W-1:0] cerr,
   output logic              halt_pulse,
   output logic              retire_pulse,
   output logic              force_timeout
);
   generate
      if (CERR_W < 1 || CERR_W > 8) begin : g_bad_cerr
         $error("CERR_W must lie in 1..8");
      end
   endgenerate

   logic [ST_W-1:0]   status_q;
   logic [CERR_W-1:0] cerr_q;
   logic              halt_q, retire_q, abort_q;
   evt_t              evt;
   logic [CERR_W-1:0] cerr_nxt;
   logic              exhausted;
   logic [ST_W-1:0]   st_nxt;
   logic              halt_c, retire_c, abort_c;

   td_result_decode #(.SPLIT_QUALIFY(SPLIT_QUALIFY)) u_dec (
      .valid(txn_valid), .code(txn_result), .speed(ep_speed),
      .periodic(periodic), .evt(evt)
   );

   td_cerr_step #(.CERR_W(CERR_W)) u_cerr (
      .cur(cerr_q), .dec(evt.xact && status_q[B_ACT]),
      .nxt(cerr_nxt), .exhausted(exhausted)
   );

   td_status_merge u_merge (
      .cur_st(status_q), .evt(evt), .last(txn_last), .exhausted(exhausted),
      .nxt_st(st_nxt), .halt(halt_c), .retire(retire_c), .abort(abort_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         cerr_q   <= '0;
         halt_q   <= 1'b0;
         retire_q <= 1'b0;
         abort_q  <= 1'b0;
      end else if (sw_load) begin
         status_q <= sw_status;
         cerr_q   <= sw_cerr;
         halt_q   <= 1'b0;
         retire_q <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         status_q <= st_nxt;
         cerr_q   <= status_q[B_ACT] ? cerr_nxt : cerr_q;
         halt_q   <= halt_c;
         retire_q <= retire_c;
         abort_q  <= abort_c;
      end
   end

   assign status        = status_q;
   assign cerr          = cerr_q;
   assign halt_pulse    = halt_q;
   assign retire_pulse  = retire_q;
   assign force_timeout = abort_q;

   AST_HALT_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (status_q[B_HLT] && !status_q[B_ACT])); // R4
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_load && !status_q[B_ACT]) |=> ($stable(status_q) && $stable(cerr_q) && !halt_q)); // R3
   AST_BABBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_load && status_q[B_ACT] && !status_q[B_BAB]) |=> (status_q[B_BAB] -> status_q[B_HLT])); // R5
   AST_CERR_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_load |=> (cerr_q <= $past(cerr_q))); // R6
   AST_ABORT_HAS_DBE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> status_q[B_DBE]); // R7
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_load |=> ((status_q[B_DBE] >= $past(status_q[B_DBE])) && (status_q[B_XER] >= $past(status_q[B_XER])) && (status_q[B_MMF] >= $past(status_q[B_MMF])))); // R9
   AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_load |=> $stable(status_q[1:0])); // R9
   AST_RETIRE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      retire_q |-> (!status_q[B_ACT] && !status_q[B_HLT] && !halt_q)); // R10
   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sw_load |=> (!halt_q && !retire_q && !abort_q)); // R2
endmodule

// File: tb/tb_td_status_updater.sv
module tb_td_status_updater;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_load = 1'b0;
   logic [7:0] sw_status = '0;
   logic [1:0] sw_cerr = '0;
   logic       txn_valid = 1'b0;
   logic [3:0] txn_result = '0;
   logic       txn_last = 1'b0;
   logic [1:0] ep_speed = '0;
   logic       periodic = 1'b0;
   logic [7:0] status;
   logic [1:0] cerr;
   logic       halt_pulse, retire_pulse, force_timeout;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [7:0] st;
      logic [1:0] ce;
      logic       h, r, a;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   td_status_updater #(.CERR_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .sw_status(sw_status),
      .sw_cerr(sw_cerr), .txn_valid(txn_valid), .txn_result(txn_result),
      .txn_last(txn_last), .ep_speed(ep_speed), .periodic(periodic),
      .status(status), .cerr(cerr), .halt_pulse(halt_pulse),
      .retire_pulse(retire_pulse), .force_timeout(force_timeout)
   );

   task automatic step(input logic ld, input logic [7:0] lst, input logic [1:0] lce,
                       input logic v, input logic [3:0] code, input logic lst_t,
                       input logic [1:0] spd, input logic per,
                       input logic [7:0] e_st, input logic [1:0] e_ce,
                       input logic e_h, input logic e_r, input logic e_a, input string tag);
      exp_t e;
      @(negedge clk);
      sw_load = ld; sw_status = lst; sw_cerr = lce;
      txn_valid = v; txn_result = code; txn_last = lst_t;
      ep_speed = spd; periodic = per;
      @(posedge clk);
      #1;
      e.st = e_st; e.ce = e_ce; e.h = e_h; e.r = e_r; e.a = e_a; e.tag = tag;
      sb.push_back(e);
      sw_load = 1'b0; txn_valid = 1'b0; txn_last = 1'b0;
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (status !== e.st || cerr !== e.ce || halt_pulse !== e.h ||
             retire_pulse !== e.r || force_timeout !== e.a) begin
            n_fail++;
            $display("FAIL %s: got st=%02h ce=%0d h=%b r=%b a=%b, expected st=%02h ce=%0d h=%b r=%b a=%b",
                     e.tag, status, cerr, halt_pulse, retire_pulse, force_timeout,
                     e.st, e.ce, e.h, e.r, e.a);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (status !== 8'h00 || cerr !== 2'd0 || halt_pulse || retire_pulse || force_timeout) begin
         n_fail++;
         $display("FAIL R1: got st=%02h ce=%0d, expected st=00 ce=0", status, cerr);
      end
      // R2: load wins over a same-cycle STALL
      step(1, 8'h83, 2'd3, 1, 4'd1, 0, 2'b10, 0, 8'h83, 2'd3, 0, 0, 0, "R2 load beats txn");
      step(0, 0, 0, 1, 4'd0, 0, 2'b10, 0, 8'h83, 2'd3, 0, 0, 0, "R10 success not last");
      step(0, 0, 0, 1, 4'd3, 0, 2'b10, 0, 8'h8B, 2'd2, 0, 0, 0, "R6 timeout decrements");
      step(0, 0, 0, 1, 4'd0, 0, 2'b10, 0, 8'h8B, 2'd2, 0, 0, 0, "R9 success keeps XER");
      step(0, 0, 0, 1, 4'd4, 0, 2'b10, 0, 8'h8B, 2'd1, 0, 0, 0, "R6 crc decrements");
      step(0, 0, 0, 1, 4'd6, 0, 2'b10, 0, 8'hAB, 2'd1, 0, 0, 1, "R7 overrun forces timeout");
      step(0, 0, 0, 1, 4'd8, 0, 2'b10, 1, 8'hAB, 2'd1, 0, 0, 0, "R8 missed on high speed ignored");
      step(0, 0, 0, 1, 4'd8, 0, 2'b00, 0, 8'hAB, 2'd1, 0, 0, 0, "R8 missed on async ignored");
      step(0, 0, 0, 1, 4'd8, 0, 2'b01, 1, 8'hAF, 2'd1, 0, 0, 0, "R8 missed low periodic sets");
      step(0, 0, 0, 1, 4'd5, 0, 2'b10, 0, 8'h6F, 2'd0, 1, 0, 0, "R6 badpid exhausts count");
      step(0, 0, 0, 1, 4'd1, 0, 2'b10, 0, 8'h6F, 2'd0, 0, 0, 0, "R3 inactive ignores stall");
      step(1, 8'h80, 2'd0, 0, 4'd0, 0, 2'b10, 0, 8'h80, 2'd0, 0, 0, 0, "R2 load");
      step(0, 0, 0, 1, 4'd3, 0, 2'b10, 0, 8'h88, 2'd0, 0, 0, 0, "R6 zero count unlimited");
      step(0, 0, 0, 1, 4'd7, 0, 2'b10, 0, 8'hA8, 2'd0, 0, 0, 0, "R7 underrun no force");
      step(0, 0, 0, 1, 4'd12, 1, 2'b10, 0, 8'hA8, 2'd0, 0, 0, 0, "R10 unused code ignored");
      step(0, 0, 0, 1, 4'd2, 0, 2'b10, 0, 8'h78, 2'd0, 1, 0, 0, "R5 babble halts");
      step(1, 8'h81, 2'd2, 0, 4'd0, 0, 2'b10, 0, 8'h81, 2'd2, 0, 0, 0, "R2 load");
      step(0, 0, 0, 1, 4'd1, 0, 2'b10, 0, 8'h41, 2'd2, 1, 0, 0, "R4 stall halts");
      step(1, 8'h82, 2'd1, 0, 4'd0, 0, 2'b10, 0, 8'h82, 2'd1, 0, 0, 0, "R2 load");
      step(0, 0, 0, 1, 4'd0, 1, 2'b10, 0, 8'h02, 2'd1, 0, 1, 0, "R10 retire on last");
      step(1, 8'h80, 2'd1, 0, 4'd0, 0, 2'b10, 0, 8'h80, 2'd1, 0, 0, 0, "R2 load");
      step(0, 0, 0, 1, 4'd3, 0, 2'b10, 0, 8'h48, 2'd0, 1, 0, 0, "R6 error and halt same cycle");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule